// File: doc/BRIEF.md
# Triple Interval Timer Counter

Three independent 16-bit up-counters share one input clock and one word-addressed register bus. Each timer has its own prescaler, its own control, interval, three match values, an event status register and an enable mask, and drives its own interrupt line. A timer either runs freely through the full 16-bit range or, in interval mode, counts from 0 up to a programmed limit and starts again. Either way it can raise events on restart, on wrap past the top value, and whenever it steps onto one of its match values.

Software programs a timer while it is stopped. It then clears and starts the timer in a single control write, and collects events by reading the status register, which empties itself on that read. The register of timer t sits at a kind offset plus 4·t, so the three copies of each register are adjacent words. Reads are combinational within the cycle that the read strobe is high. Writes take effect at that cycle's clock edge.

Top module: `ttc_triple`

## Requirements
- R1: After reset every timer's counter control reads 0x01 (stopped), its counter, prescaler control, interval, match, status and enable registers read 0, and every interrupt output is low.
- R2: Counter control bit 0 stops the timer. While it is 1 the counter value does not change. After it is written to 0 the counter advances from the value it held, starting with the edge after that write.
- R3: A timer that is not in interval mode (or whose interval value is 0) steps from 0xFFFF to 0, and that step sets status bit 4.
- R4: With counter control bit 1 set and a non-zero interval value I, the counter runs 0, 1, …, I, 0, …, and the step from I to 0 sets status bit 0.
- R5: Prescaler control bit 0 enables division and bits [4:1] hold S. The counter then advances once every 2^(S+1) clocks (0x9 gives 32). With bit 0 clear it advances every clock. After a restart at edge E the count after edge E+m is floor(m / divisor).
- R6: Writing counter control with bit 4 set zeroes the counter and the prescaler phase at that edge. Bit 4 reads back as 0, and the other written bits read back as written.
- R7: Each time the counter steps onto the value of match register k (k = 1, 2, 3), status bit k is set. A step to 0 caused by restart or wrap also counts.
- R8: Status bits stay set until the status register is read. That read clears them at the edge, except for events of the same cycle. Writes to the status register are ignored.
- R9: A timer's interrupt output is high exactly when some status bit is set whose enable register bit is also set.
- R10: Byte address = kind offset + 4·t for timer t (0..2). The kind offsets are prescaler control 0x00, counter control 0x0C, counter value 0x18 (read-only, writes ignored), interval 0x24, match 1/2/3 0x30/0x3C/0x48, status 0x54 and enable 0x60. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for bus and all timers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, register updated at this edge |
| bus_rd | input | 1 | Read strobe; read data valid in the same cycle |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when no valid read |
| irq | output | 3 | One interrupt line per timer |

## Verification
The hardest condition to reach from the ports is the overflow event. A free-running counter only wraps after 65536 unscaled steps, and the counter, status and match contents must all be known at that moment. The bench clears the status, restarts timer 0 with the reset bit at a known edge, and idles until two reads away from the top. It then reads 0xFFFE, 0xFFFF and 0, and finally expects overflow plus the three match bits of the default zero match values. The prescaler and interval cases are swept read by read from a known restart edge, with the expected count computed as floor(m/divisor) or m mod (I+1).

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  // register kinds, in address order (kind offset = kind * 4 * timers)
  localparam int NKIND     = 9;
  localparam int K_CLK     = 0;
  localparam int K_CTL     = 1;
  localparam int K_CNT     = 2;
  localparam int K_IVL     = 3;
  localparam int K_M1      = 4;
  localparam int K_STAT    = 7;
  localparam int K_IER     = 8;
  localparam int KIND_W    = 4;
  // counter control bits
  localparam int CTL_W     = 6;
  localparam int CTL_DIS   = 0;
  localparam int CTL_IMODE = 1;
  localparam int CTL_CLR   = 4;
  // status bits
  localparam int STAT_W    = 5;
  localparam int ST_IVL    = 0;
  localparam int ST_OVF    = 4;
  localparam int N_MATCH   = 3;
endpackage

// File: rtl/ttc_prescaler.sv
module ttc_prescaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PW = 1 << SEL_W;

  logic [PW-1:0] phase_q;
  logic          at_last;

  // last phase of a 2^(sel+1) division
  function automatic logic [PW:0] last_phase(input logic [SEL_W-1:0] s);
    return ((PW+1)'(1) << (int'(s) + 1)) - (PW+1)'(1);
  endfunction

  assign at_last = ({1'b0, phase_q} == last_phase(sel));
  assign tick    = run & (~en | at_last);

  always_ff @(posedge clk) begin
    if (!rst_n)          phase_q <= '0;
    else if (clr || !en) phase_q <= '0;
    else if (run)        phase_q <= at_last ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/ttc_regdec.sv
module ttc_regdec
  import ttc_pkg::*;
#(
  parameter int N_TMR  = 3,
  parameter int ADDR_W = 8,
  localparam int TW    = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              wr,
  input  logic                              rd,
  output logic                              hit,
  output logic [TW-1:0]                     tmr,
  output logic [KIND_W-1:0]                 kind,
  output logic [N_TMR-1:0][NKIND-1:0]       wr_sel,
  output logic [N_TMR-1:0]                  stat_rd
);
  localparam int NWORDS = NKIND * N_TMR;

  int unsigned widx;

  always_comb begin
    widx    = int'(addr[ADDR_W-1:2]);
    hit     = (addr[1:0] == 2'b00) && (widx < NWORDS);
    kind    = KIND_W'(widx / N_TMR);
    tmr     = TW'(widx % N_TMR);
    wr_sel  = '0;
    stat_rd = '0;
    if (hit && wr) wr_sel[tmr][kind] = 1'b1;
    if (hit && rd && (int'(kind) == K_STAT)) stat_rd[tmr] = 1'b1;
  end
endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
  import ttc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NKIND-1:0]              wr_sel,
  input  logic [CNT_W-1:0]              wdata,
  input  logic                          stat_rd,
  output logic [NKIND-1:0][CNT_W-1:0]   bank,
  output logic                          irq,
  output logic [STAT_W-1:0]             ev,
  output logic [STAT_W-1:0]             stat,
  output logic [CNT_W-1:0]              cnt,
  output logic                          run,
  output logic                          cnt_clr
);
  logic [SEL_W:0]      clk_q;
  logic [CTL_W-1:0]    ctl_q;
  logic [CNT_W-1:0]    ivl_q;
  logic [CNT_W-1:0]    mat_q [N_MATCH];
  logic [STAT_W-1:0]   ier_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [STAT_W-1:0]   stat_q;
  logic                tick, step, ivl_hit, top_hit;
  logic [CNT_W-1:0]    cnt_nx;

  // next counter value: restart at the interval limit, else natural wrap
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] lim,
                                                  input logic imode);
    if (imode && (lim != '0) && (cur == lim)) return '0;
    return cur + 1'b1;
  endfunction

  assign run     = ~ctl_q[CTL_DIS];
  assign cnt_clr = wr_sel[K_CTL] & wdata[CTL_CLR];

  ttc_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .clr  (cnt_clr),
    .en   (clk_q[0]),
    .sel  (clk_q[SEL_W:1]),
    .tick (tick)
  );

  assign step    = tick & ~cnt_clr;
  assign ivl_hit = ctl_q[CTL_IMODE] && (ivl_q != '0) && (cnt_q == ivl_q);
  assign top_hit = (&cnt_q) && !ivl_hit;
  assign cnt_nx  = next_count(cnt_q, ivl_q, ctl_q[CTL_IMODE]);

  assign ev[ST_IVL] = step & ivl_hit;
  assign ev[ST_OVF] = step & top_hit;
  for (genvar k = 0; k < N_MATCH; k++) begin : g_match
    assign ev[k+1] = step & (cnt_nx == mat_q[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q  <= '0;
      ctl_q  <= CTL_W'(1) << CTL_DIS;
      ivl_q  <= '0;
      ier_q  <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_sel[K_CLK]) clk_q <= wdata[SEL_W:0];
      if (wr_sel[K_CTL]) ctl_q <= wdata[CTL_W-1:0] & ~(CTL_W'(1) << CTL_CLR);
      if (wr_sel[K_IVL]) ivl_q <= wdata;
      if (wr_sel[K_IER]) ier_q <= wdata[STAT_W-1:0];
      if (cnt_clr)       cnt_q <= '0;
      else if (step)     cnt_q <= cnt_nx;
      stat_q <= (stat_rd ? '0 : stat_q) | ev;
    end
  end

  for (genvar k = 0; k < N_MATCH; k++) begin : g_mreg
    always_ff @(posedge clk) begin
      if (!rst_n)              mat_q[k] <= '0;
      else if (wr_sel[K_M1+k]) mat_q[k] <= wdata;
    end
  end

  always_comb begin
    bank         = '0;
    bank[K_CLK]  = CNT_W'(clk_q);
    bank[K_CTL]  = CNT_W'(ctl_q);
    bank[K_CNT]  = cnt_q;
    bank[K_IVL]  = ivl_q;
    for (int k = 0; k < N_MATCH; k++) bank[K_M1+k] = mat_q[k];
    bank[K_STAT] = CNT_W'(stat_q);
    bank[K_IER]  = CNT_W'(ier_q);
  end

  assign irq  = |(stat_q & ier_q);
  assign stat = stat_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/ttc_triple.sv
module ttc_triple
  import ttc_pkg::*;
#(
  parameter int N_TMR  = 3,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [N_TMR-1:0]  irq
);
  localparam int TW = (N_TMR > 1) ? $clog2(N_TMR) : 1;

  logic                                   hit;
  logic [TW-1:0]                          tmr;
  logic [KIND_W-1:0]                      kind;
  logic [N_TMR-1:0][NKIND-1:0]            wr_sel;
  logic [N_TMR-1:0]                       stat_rd;
  logic [N_TMR-1:0][NKIND-1:0][CNT_W-1:0] bank_all;
  logic [N_TMR-1:0][STAT_W-1:0]           ev_all;
  logic [N_TMR-1:0][STAT_W-1:0]           stat_all;
  logic [N_TMR-1:0][CNT_W-1:0]            cnt_all;
  logic [N_TMR-1:0]                       run_all;
  logic [N_TMR-1:0]                       clr_all;

  ttc_regdec #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .hit    (hit),
    .tmr    (tmr),
    .kind   (kind),
    .wr_sel (wr_sel),
    .stat_rd(stat_rd)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    ttc_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (wr_sel[t]),
      .wdata  (bus_wdata),
      .stat_rd(stat_rd[t]),
      .bank   (bank_all[t]),
      .irq    (irq[t]),
      .ev     (ev_all[t]),
      .stat   (stat_all[t]),
      .cnt    (cnt_all[t]),
      .run    (run_all[t]),
      .cnt_clr(clr_all[t])
    );
  end

  assign bus_rdata = (bus_rd && hit) ? bank_all[tmr][kind] : '0;
endmodule

// File: rtl/ttc_triple_chk.sv
module ttc_triple_chk
  import ttc_pkg::*;
#(
  parameter int N_TMR = 3,
  parameter int CNT_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N_TMR-1:0]             irq,
  input logic [N_TMR-1:0][STAT_W-1:0] ev_all,
  input logic [N_TMR-1:0][STAT_W-1:0] stat_all,
  input logic [N_TMR-1:0][CNT_W-1:0]  cnt_all,
  input logic [N_TMR-1:0]             run_all,
  input logic [N_TMR-1:0]             clr_all,
  input logic [N_TMR-1:0]             stat_rd
);
  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_all[i] && !clr_all[i]) |=> $stable(cnt_all[i]));
    // R6
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all[i] |=> (cnt_all[i] == '0));
    // R3
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_all[i][ST_OVF] |=> (cnt_all[i] == '0));
    // R4
    ivl_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_all[i][ST_IVL] |=> (cnt_all[i] == '0));
    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd[i] && (ev_all[i] == '0)) |=> (stat_all[i] == '0));
    // R8
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd[i] |=> ((stat_all[i] & $past(stat_all[i])) == $past(stat_all[i])));
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (stat_all[i] != '0));
  end
endmodule

bind ttc_triple ttc_triple_chk #(.N_TMR(N_TMR), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .ev_all  (ev_all),
  .stat_all(stat_all),
  .cnt_all (cnt_all),
  .run_all (run_all),
  .clr_all (clr_all),
  .stat_rd (stat_rd)
);

// File: tb/ttc_triple_tb.sv
`timescale 1ns/1ps
module ttc_triple_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  irq;
  int checks = 0;
  int errors = 0;
  logic [15:0] v, v1;

  always #10 clk = ~clk;

  ttc_triple u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // kind numbering: clk 0, ctl 1, cnt 2, ivl 3, m1..m3 4..6, stat 7, ier 8
  function automatic logic [7:0] ad(input int kind, input int t);
    return 8'(kind * 12 + 4 * t);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    for (int t = 0; t < 3; t++) begin
      rd(ad(1, t), v); chk("R1 ctl", v, 16'h0001);
      rd(ad(2, t), v); chk("R1 cnt", v, 0);
      rd(ad(0, t), v); chk("R1 clk", v, 0);
      rd(ad(3, t), v); chk("R1 ivl", v, 0);
      rd(ad(5, t), v); chk("R1 m2", v, 0);
      rd(ad(7, t), v); chk("R1 stat", v, 0);
      rd(ad(8, t), v); chk("R1 ier", v, 0);
    end

    // R10 map and read-only counter
    wr(ad(3, 2), 16'h1234);
    rd(ad(3, 2), v); chk("R10 t2 ivl", v, 16'h1234);
    rd(ad(3, 0), v); chk("R10 t0 ivl", v, 0);
    rd(ad(3, 1), v); chk("R10 t1 ivl", v, 0);
    wr(ad(2, 0), 16'h5555);
    rd(ad(2, 0), v); chk("R10 cnt ro", v, 0);
    rd(8'd108, v); chk("R10 unmapped", v, 0);
    wr(ad(3, 2), 16'h0000);

    // R5 prescaler sweep on timer 0, restart via R6 reset bit
    for (int c = -1; c <= 4; c++) begin
      int dv;
      dv = (c < 0) ? 1 : (1 << (c + 1));
      wr(ad(0, 0), (c < 0) ? 16'h0 : 16'((c << 1) | 1));
      wr(ad(1, 0), 16'h0010);
      for (int j = 0; j < 70; j++) begin
        rd(ad(2, 0), v);
        chk("R5 prescaled count", v, 32'(j / dv));
      end
    end

    // R2 stop holds, restart resumes
    wr(ad(1, 0), 16'h0001);
    rd(ad(2, 0), v1);
    idle(10);
    rd(ad(2, 0), v); chk("R2 hold", v, v1);
    wr(ad(0, 0), 16'h0000);
    wr(ad(1, 0), 16'h0000);
    rd(ad(2, 0), v); chk("R2 resume first", v, v1);
    rd(ad(2, 0), v); chk("R2 resume step", v, v1 + 16'd1);

    // R4 interval sweep on timer 1, R6 readback
    for (int lim = 1; lim <= 6; lim++) begin
      wr(ad(3, 1), 16'(lim));
      wr(ad(1, 1), 16'h0012);
      for (int j = 0; j < 20; j++) begin
        rd(ad(2, 1), v);
        chk("R4 interval count", v, 32'(j % (lim + 1)));
      end
      rd(ad(1, 1), v); chk("R6 ctl readback", v, 16'h0002);
      wr(ad(1, 1), 16'h0003);
      rd(ad(1, 1), v); chk("R6 ctl stopped", v, 16'h0003);
      // restart + three zero matches; no overflow
      rd(ad(7, 1), v); chk("R4 stat", v, 16'h000F);
      rd(ad(7, 1), v); chk("R8 cleared", v, 0);
    end

    // R7 match events on timer 2
    wr(ad(4, 2), 16'd5);
    wr(ad(5, 2), 16'd9);
    wr(ad(6, 2), 16'd200);
    wr(ad(1, 2), 16'h0010);
    idle(3);
    rd(ad(7, 2), v); chk("R7 before match", v, 0);
    idle(1);
    rd(ad(7, 2), v); chk("R7 match1", v, 16'h0002);
    idle(3);
    wr(ad(7, 2), 16'h0000);
    rd(ad(7, 2), v); chk("R7 R8 match2 write ignored", v, 16'h0004);
    wr(ad(1, 2), 16'h0001);

    // R9 interrupt masking on timer 1
    wr(ad(3, 1), 16'd3);
    wr(ad(8, 1), 16'h0001);
    wr(ad(1, 1), 16'h0012);
    for (int m = 0; m < 6; m++) begin
      #2 chk("R9 irq1 timing", 32'(irq[1]), (m >= 4) ? 1 : 0);
      idle(1);
    end
    chk("R9 irq0 masked", 32'(irq[0]), 0);
    chk("R9 irq2 masked", 32'(irq[2]), 0);
    wr(ad(8, 1), 16'h0000);
    #2 chk("R9 mask off", 32'(irq[1]), 0);
    wr(ad(8, 1), 16'h0001);
    #2 chk("R9 mask on", 32'(irq[1]), 1);
    wr(ad(1, 1), 16'h0003);
    rd(ad(7, 1), v);
    #2 chk("R9 R8 irq after clear", 32'(irq[1]), 0);

    // R3 full wrap on timer 0
    wr(ad(1, 0), 16'h0001);
    rd(ad(7, 0), v);
    wr(ad(1, 0), 16'h0010);
    idle(65534);
    rd(ad(2, 0), v); chk("R3 near top", v, 16'hFFFE);
    rd(ad(2, 0), v); chk("R3 top", v, 16'hFFFF);
    rd(ad(2, 0), v); chk("R3 wrapped", v, 0);
    rd(ad(7, 0), v); chk("R3 overflow status", v, 16'h001E);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule